// File: doc/BRIEF.md
# Gate Passage Counter

This block counts objects moving through a gate fitted with two presence detectors placed one after the other along the direction of travel. An object moving forward first covers the entry detector, then covers both, then uncovers the entry detector while still covering the exit detector, and finally clears both. A three-state synchronous controller samples the two detector bits on every rising clock edge and follows this progression. An object that backs out, or that arrives from the exit side, produces no count.

When a complete forward passage ends, the controller raises a count pulse for one cycle. This pulse is a combinational function of the current state and the detector bits. The pulse advances a decade counter whose value is presented as a 4-bit BCD digit. The digit wraps from 9 to 0. An active-high asynchronous reset returns both the controller and the digit to their idle values. All pins are plain level signals. The block has no data stream, so it has no valid/ready handshake and no back-pressure.

Top module: `gate_tally`

## Requirements
- R1: While `rst` is high, the controller is idle and `tally` reads 0. While `rst` is high and both detector bits are 0, `tally_pulse` reads 0.
- R2: In the idle state, entry=1 with exit=0 moves the controller to the entered state. Every other detector combination keeps it idle.
- R3: In the entered state, both detectors high moves the controller to the covered state. Both detectors low returns it to idle. Any other combination keeps it in the entered state.
- R4: In the covered state, both detectors low returns the controller to idle. Entry=1 with exit=0 returns it to the entered state. Any other combination keeps it in the covered state.
- R5: `tally_pulse` is high exactly when the controller is in the covered state and both detectors are low, in the same cycle. It is never high for two cycles in a row.
- R6: A rising clock edge that finds `tally_pulse` high raises `tally` by one.
- R7: When `tally` is 9 and a pulse is taken, `tally` becomes 0. `tally` never exceeds 9, so ten forward passages leave the digit where it began.
- R8: An object that arrives from the exit side (exit detector first, then both, then entry only, then none) leaves `tally` unchanged.
- R9: An object that covers the entry detector and then backs out leaves `tally` unchanged. This holds whether it backs out before reaching the exit detector or after covering both detectors.
- R10: In any cycle without a pulse, `tally` keeps its value on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Active-high asynchronous reset |
| det_a | input | 1 | Entry detector, 1 = covered |
| det_b | input | 1 | Exit detector, 1 = covered |
| tally_pulse | output | 1 | One-cycle count pulse, combinational from state and detectors |
| tally | output | 4 | BCD count digit, 0 to 9 |

## Verification
The block is tried with four kinds of detector pattern.

- Clean forward passages are run in runs long enough to cross the 9-to-0 wrap. They show that each passage counts exactly once.
- Objects entering from the exit side are run, and they must never count. This separates a design that orders the two detectors from one that only looks for both being covered.
- Entries that back out are run, both before and after the covered state. These expose a controller that counts whenever it leaves the covered state, rather than only on the all-clear exit.
- Long dwells with one or both detectors held are run. These show that state is kept and that no repeated pulses appear while an object lingers.

// File: rtl/gate_tally_pkg.sv
package gate_tally_pkg;

  typedef enum logic [1:0] {
    GT_IDLE    = 2'd0,
    GT_ENTERED = 2'd1,
    GT_COVERED = 2'd2
  } gt_state_t;

endpackage

// File: rtl/gate_passage_fsm.sv
module gate_passage_fsm
  import gate_tally_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic det_a,
  input  logic det_b,
  output logic pass_done
);

  gt_state_t cur_q;
  gt_state_t nxt;

  always_comb begin
    nxt = cur_q;
    unique case (cur_q)
      GT_IDLE: begin
        if (det_a && !det_b) nxt = GT_ENTERED;
      end
      GT_ENTERED: begin
        if (det_a && det_b)        nxt = GT_COVERED;
        else if (!det_a && !det_b) nxt = GT_IDLE;
      end
      GT_COVERED: begin
        if (!det_a && !det_b)     nxt = GT_IDLE;
        else if (det_a && !det_b) nxt = GT_ENTERED;
      end
      default: nxt = GT_IDLE;
    endcase
  end

  // Mealy exit: the all-clear seen while covered
  assign pass_done = (cur_q == GT_COVERED) && !det_a && !det_b;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) cur_q <= GT_IDLE;
    else     cur_q <= nxt;
  end

  AST_IDLE_TO_ENTERED: assert property (@(posedge clk) disable iff (rst)
    (cur_q == GT_IDLE && det_a && !det_b) |=> (cur_q == GT_ENTERED)); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (cur_q == GT_IDLE && !(det_a && !det_b)) |=> (cur_q == GT_IDLE)); // R2

  AST_ENTERED_TO_COVERED: assert property (@(posedge clk) disable iff (rst)
    (cur_q == GT_ENTERED && det_a && det_b) |=> (cur_q == GT_COVERED)); // R3

  AST_ENTERED_BACKOUT: assert property (@(posedge clk) disable iff (rst)
    (cur_q == GT_ENTERED && !det_a && !det_b) |=> (cur_q == GT_IDLE)); // R3

  AST_COVERED_EXIT: assert property (@(posedge clk) disable iff (rst)
    (cur_q == GT_COVERED && !det_a && !det_b) |=> (cur_q == GT_IDLE)); // R4

  AST_COVERED_REVERSE: assert property (@(posedge clk) disable iff (rst)
    (cur_q == GT_COVERED && det_a && !det_b) |=> (cur_q == GT_ENTERED)); // R4

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    pass_done |=> !pass_done); // R5

endmodule

// File: rtl/decade_digit.sv
module decade_digit #(
  parameter int DIGIT_W = 4,
  parameter int MODULUS = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inc,
  output logic [DIGIT_W-1:0] digit
);

  localparam logic [DIGIT_W-1:0] LAST = DIGIT_W'(MODULUS - 1);
  localparam logic [DIGIT_W-1:0] ONE  = DIGIT_W'(1);

  logic [DIGIT_W-1:0] val_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)                 val_q <= '0;
    else if (inc) begin
      if (val_q == LAST)     val_q <= '0;
      else                   val_q <= val_q + ONE;
    end
  end

  assign digit = val_q;

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (inc && val_q != LAST) |=> (val_q == $past(val_q) + ONE)); // R6

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (inc && val_q == LAST) |=> (val_q == '0)); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    val_q <= LAST); // R7

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(val_q)); // R10

endmodule

// File: rtl/gate_tally.sv
module gate_tally #(
  parameter int DIGIT_W = 4,
  parameter int MODULUS = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               det_a,
  input  logic               det_b,
  output logic               tally_pulse,
  output logic [DIGIT_W-1:0] tally
);

  logic done_w;

  gate_passage_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .det_a     (det_a),
    .det_b     (det_b),
    .pass_done (done_w)
  );

  decade_digit #(
    .DIGIT_W (DIGIT_W),
    .MODULUS (MODULUS)
  ) u_digit (
    .clk   (clk),
    .rst   (rst),
    .inc   (done_w),
    .digit (tally)
  );

  assign tally_pulse = done_w;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |-> (tally == '0)); // R1

endmodule

// File: tb/sim_gate_tally.sv
module sim_gate_tally;

  localparam int PERIOD = 10;

  typedef struct {
    logic       pulse;
    logic [3:0] cnt;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic da  = 1'b0;
  logic db  = 1'b0;
  logic       pulse;
  logic [3:0] cnt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  exp_t sb[$];

  // bench model: 0 idle, 1 entered, 2 covered
  int m_st  = 0;
  int m_cnt = 0;

  always #(PERIOD/2) clk = ~clk;

  gate_tally u0 (
    .clk         (clk),
    .rst         (rst),
    .det_a       (da),
    .det_b       (db),
    .tally_pulse (pulse),
    .tally       (cnt)
  );

  task automatic check(input logic c, input string tag,
                       input int act, input int exp);
    checks++;
    if (!c) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // driver: drive one cycle of detector bits, push expectation, step model
  task automatic step(input logic a, input logic b, input string tag);
    exp_t e;
    bit p;
    @(posedge clk);
    #1;
    da = a;
    db = b;
    p = (m_st == 2) && !a && !b;
    e.pulse = p;
    e.cnt   = 4'(m_cnt);
    e.tag   = tag;
    sb.push_back(e);
    case (m_st)
      0: if (a && !b) m_st = 1;
      1: if (a && b) m_st = 2; else if (!a && !b) m_st = 0;
      default: if (!a && !b) m_st = 0; else if (a && !b) m_st = 1;
    endcase
    if (p) m_cnt = (m_cnt == 9) ? 0 : m_cnt + 1;
  endtask

  task automatic forward(input string tag);
    step(1'b1, 1'b0, tag);
    step(1'b1, 1'b1, tag);
    step(1'b0, 1'b1, tag);
    step(1'b0, 1'b0, tag);
    step(1'b0, 1'b0, tag);
  endtask

  // monitor: pop and compare away from the active edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(pulse === e.pulse, {e.tag, " pulse"}, int'(pulse), int'(e.pulse));
      check(cnt === e.cnt, {e.tag, " tally"}, int'(cnt), int'(e.cnt));
    end
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int base;
    @(negedge clk);
    check(cnt === 4'd0, "R1 reset tally", int'(cnt), 0);
    check(pulse === 1'b0, "R1 reset pulse", int'(pulse), 0);
    @(posedge clk);
    #1 rst = 1'b0;

    // R10: idle dwell, no change
    step(1'b0, 1'b0, "R10 idle");
    step(1'b0, 1'b1, "R2 idle stays on exit-only");
    step(1'b1, 1'b1, "R2 idle stays on both");
    step(1'b0, 1'b0, "R2 idle");

    // single forward passage, R5 R6
    forward("R5 R6 forward");

    // forward with dwells: R3 R4 holds
    step(1'b1, 1'b0, "R2 enter");
    step(1'b1, 1'b0, "R3 hold entered");
    step(1'b0, 1'b1, "R3 hold entered on exit-only");
    step(1'b1, 1'b1, "R3 to covered");
    step(1'b1, 1'b1, "R4 hold covered");
    step(1'b0, 1'b1, "R4 hold covered");
    step(1'b0, 1'b1, "R4 hold covered");
    step(1'b0, 1'b0, "R4 R5 exit pulse");
    step(1'b0, 1'b0, "R5 R6 after pulse");

    // R8: from exit side
    base = m_cnt;
    step(1'b0, 1'b1, "R8 reverse");
    step(1'b1, 1'b1, "R8 reverse");
    step(1'b1, 1'b0, "R8 reverse");
    step(1'b0, 1'b0, "R8 reverse");
    step(1'b0, 1'b0, "R8 reverse");
    @(negedge clk);
    check(cnt === 4'(base), "R8 unchanged", int'(cnt), base);

    // R9: back out before covered, and after covered
    step(1'b1, 1'b0, "R9 backout");
    step(1'b0, 1'b0, "R9 backout");
    step(1'b1, 1'b0, "R9 backout late");
    step(1'b1, 1'b1, "R9 backout late");
    step(1'b1, 1'b0, "R4 R9 covered to entered");
    step(1'b0, 1'b0, "R3 R9 entered to idle");
    step(1'b0, 1'b0, "R9 backout late");
    @(negedge clk);
    check(cnt === 4'(base), "R9 unchanged", int'(cnt), base);

    // R7: ten passages return to the same digit, crossing 9 -> 0
    base = m_cnt;
    for (int i = 0; i < 10; i++) forward("R7 wrap run");
    @(negedge clk);
    check(cnt === 4'(base), "R7 ten passages", int'(cnt), base);
    for (int i = 0; i < 8; i++) forward("R7 approach");

    // R1: mid-run reset
    @(posedge clk);
    #1 rst = 1'b1;
    m_st = 0;
    m_cnt = 0;
    @(negedge clk);
    check(cnt === 4'd0, "R1 mid reset tally", int'(cnt), 0);
    @(posedge clk);
    #1 rst = 1'b0;
    forward("R1 R6 after reset");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule